// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor front end and the first-level cache controller. It keeps a record of every memory request that is still in flight. Loads and instruction fetches are recorded in a read table. Stores and atomic read-modify-writes are recorded in a write table. Both tables are keyed by the cache-line address, which is the request address with its byte-offset bits cleared.

In the cycle a request is presented, the tracker decides whether to accept it. An accepted request receives a unique identifier and a timestamp taken from a free-running cycle counter. In the same cycle the request is forwarded, translated, on either the instruction-cache path or the data-cache path. A refused request receives the all-ones identifier.

When the cache controller reports that a line has completed, the matching entry is retired. The tracker then returns the stored identifier, the stored byte offset, length and kind, the completion data, and the miss latency. A periodic watchdog inspects the age of every live entry and raises a sticky deadlock flag when an entry has waited too long.

Top module: `req_tracker`

## Requirements
- R1: Request kind is encoded on `req_kind` as 0 load, 1 instruction fetch, 2 store, 3 read-modify-write. Kinds 2 and 3 (bit 1 set) enter the write table and kinds 0 and 1 enter the read table. A completion retires an entry only from the table selected by `cpl_wr` (1 selects the write table).
- R2: A request is refused while `outstanding` is at or above `MAX_OUT`, even when its own table still has room.
- R3: A request is refused when either table already holds a live entry whose line address (address bits above the low `OFF_W` = 6 bits) equals the request's line address.
- R4: Identifiers are handed out to accepted requests in increasing order starting at 0 after reset. A refused request, for any reason, shows `req_id` equal to all ones.
- R5: A request whose byte offset plus length exceeds the 64-byte line raises `req_err` and is refused. An offset plus length of exactly 64 is legal.
- R6: The forwarded kind `iss_kind` is encoded 0 load, 1 store, 2 atomic, 3 instruction fetch. A read-modify-write request is forwarded as atomic.
- R7: `iss_super` is 1 only for supervisor mode (`req_mode` = 1). User (0) and device (2) modes are forwarded as user (`iss_super` = 0).
- R8: An accepted instruction fetch raises `iss_i_valid` only. Every other accepted kind raises `iss_d_valid` only. A refused request raises neither.
- R9: A completion that matches a live entry in the selected table raises `done_valid` in the same cycle. It returns that entry's identifier, byte offset, length and kind, passes `cpl_data` through to `done_data`, and lowers `outstanding` by one on the next cycle. A completion that matches no entry raises `cpl_miss` and changes nothing.
- R10: `latency` equals the number of cycles from the cycle of acceptance to the cycle of completion. `lat_valid` is raised with `done_valid` only when that count is non-zero.
- R11: The watchdog arms on an acceptance while it is idle and fires `DL_THRESH` cycles later. When it fires, any live entry whose age is at least `DL_THRESH` sets `deadlock`, which stays set until reset. After firing, the watchdog re-arms if entries remain and goes idle otherwise.
- R12: An acceptance and a completion in the same cycle are both carried out. `outstanding` always equals the number of live entries across both tables.
- R13: Each table holds `ENTRIES` lines. A request is refused when its own table is full, even below `MAX_OUT`, while the other table still accepts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | New request present |
| req_kind | input | 2 | Request kind (R1 encoding) |
| req_mode | input | 2 | Access mode: 0 user, 1 supervisor, 2 device |
| req_addr | input | 32 | Byte address |
| req_len | input | 7 | Length in bytes |
| req_accept | output | 1 | Request accepted this cycle |
| req_err | output | 1 | Request crosses the line boundary |
| req_id | output | 16 | Assigned identifier, all ones when refused |
| iss_i_valid | output | 1 | Forward on instruction-cache path |
| iss_d_valid | output | 1 | Forward on data-cache path |
| iss_line | output | 26 | Forwarded line address |
| iss_off | output | 6 | Forwarded byte offset |
| iss_len | output | 7 | Forwarded length |
| iss_kind | output | 2 | Forwarded cache request kind (R6 encoding) |
| iss_super | output | 1 | Forwarded supervisor mode |
| cpl_valid | input | 1 | Completion from cache controller |
| cpl_wr | input | 1 | Completion targets the write table |
| cpl_line | input | 26 | Completed line address |
| cpl_data | input | 64 | Completion data |
| done_valid | output | 1 | Completion matched and retired |
| cpl_miss | output | 1 | Completion matched nothing |
| done_id | output | 16 | Identifier of the retired request |
| done_kind | output | 2 | Request kind of the retired request |
| done_off | output | 6 | Byte offset of the retired request |
| done_len | output | 7 | Length of the retired request |
| done_data | output | 64 | Completion data passed through |
| lat_valid | output | 1 | Non-zero latency reported |
| latency | output | 32 | Cycles from acceptance to completion |
| outstanding | output | 5 | Live entries across both tables |
| deadlock | output | 1 | Sticky watchdog deadlock flag |

## Verification
The bench targets duplicate lines that sit in the opposite table. A tracker that searched only the target table would accept a store on the line of a pending fetch. It also drives a completion aimed at the wrong table. A tracker that ignored `cpl_wr` would retire the store and raise `done_valid` where a miss is due. It fills the read table while the total stays below the cap, and then fills the total to the cap while the write table still has room. A tracker that checked only one of the two limits accepts in one of those cases. It issues a request and a completion in the same cycle, which exposes a counter that updates only one of them. Finally it times the watchdog against a quiet idle period and a held request. This exposes both a watchdog that fires while nothing is pending and a deadlock flag that clears itself.

// File: rtl/req_tracker_pkg.sv
// Shared widths, kind encodings and the table entry layout for the
// outstanding memory request tracker. Assumes 64-byte lines.
package req_tracker_pkg;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 6;
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int LEN_W  = OFF_W + 1;
    localparam int ID_W   = 16;
    localparam int TS_W   = 32;
    localparam int LINE_BYTES = 1 << OFF_W;

    // Front-end request kinds; bit 1 set marks the write class.
    typedef enum logic [1:0] {
        RQ_LOAD   = 2'd0,
        RQ_IFETCH = 2'd1,
        RQ_STORE  = 2'd2,
        RQ_RMW    = 2'd3
    } rq_kind_e;

    // Kinds forwarded to the cache controller.
    typedef enum logic [1:0] {
        CQ_LD     = 2'd0,
        CQ_ST     = 2'd1,
        CQ_ATOMIC = 2'd2,
        CQ_IFETCH = 2'd3
    } cq_kind_e;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [ID_W-1:0]   id;
        logic [1:0]        kind;
        logic [OFF_W-1:0]  off;
        logic [LEN_W-1:0]  len;
        logic [TS_W-1:0]   ts;
    } slot_t;
endpackage

// File: rtl/rt_table.sv
// Fully associative table of in-flight lines. Offers a probe port for
// duplicate detection, a completion port that retires a matching entry,
// an insert port that fills the lowest free slot, and an age flag for the
// watchdog. Assumes the caller never inserts while full and never inserts
// a line that is already present.
module rt_table
    import req_tracker_pkg::*;
#(
    parameter int ENTRIES   = 8,
    parameter int THRESH    = 1024,
    parameter int IDX_W     = $clog2(ENTRIES),
    parameter int OCC_W     = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] probe_line,
    output logic              probe_hit,
    input  logic              ins_en,
    input  slot_t             ins_slot,
    input  logic              cpl_en,
    input  logic [LINE_W-1:0] cpl_line,
    output logic              cpl_hit,
    output slot_t             cpl_slot,
    input  logic [TS_W-1:0]   now,
    output logic              aged,
    output logic              full,
    output logic [OCC_W-1:0]  occ
);
    logic [ENTRIES-1:0] vld;
    slot_t              slot_q [ENTRIES];
    logic [ENTRIES-1:0] probe_m, cpl_m, old_m, set_m;
    logic [IDX_W-1:0]   free_idx;

    // Per-entry line compares and age test.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign probe_m[g] = vld[g] && (slot_q[g].line == probe_line);
        assign cpl_m[g]   = vld[g] && (slot_q[g].line == cpl_line);
        assign old_m[g]   = vld[g] && ((now - slot_q[g].ts) >= TS_W'(THRESH));
        assign set_m[g]   = ins_en && (free_idx == IDX_W'(g));
    end

    assign probe_hit = |probe_m;
    assign cpl_hit   = |cpl_m;
    assign aged      = |old_m;
    assign full      = &vld;
    assign occ       = OCC_W'($countones(vld));

    // Lowest-numbered free slot.
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (!vld[i]) free_idx = IDX_W'(i);
    end

    // Select the fields of the single matching entry.
    always_comb begin
        cpl_slot = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (cpl_m[i]) cpl_slot = slot_q[i];
    end

    // Valid bits: retire on completion, set on insert.
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= '0;
        else        vld <= (vld & ~(cpl_en ? cpl_m : '0)) | set_m;
    end

    // Entry payload, written on insert.
    always_ff @(posedge clk) begin
        if (ins_en) slot_q[free_idx] <= ins_slot;
    end
endmodule

// File: rtl/rt_watchdog.sv
// Periodic deadlock watchdog timer. Arms on an insert while idle, fires
// once THRESH cycles later, then re-arms while entries remain.
// Assumes THRESH >= 1.
module rt_watchdog #(
    parameter int THRESH = 1024,
    parameter int TW     = $clog2(THRESH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic any_left,
    output logic fire
);
    logic          armed;
    logic [TW-1:0] left;

    assign fire = armed && (left == '0);

    // Countdown with arm, re-arm and idle decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            left  <= '0;
        end else if (fire) begin
            armed <= any_left;
            left  <= TW'(THRESH - 1);
        end else if (armed) begin
            left  <= left - 1'b1;
        end else if (arm_req) begin
            armed <= 1'b1;
            left  <= TW'(THRESH - 1);
        end
    end
endmodule

// File: rtl/rt_xlate.sv
// Translates a front-end request kind and access mode into the cache
// request kind, the supervisor bit and the path choice. Purely combinational.
module rt_xlate
    import req_tracker_pkg::*;
(
    input  logic [1:0] kind,
    input  logic [1:0] mode,
    output logic [1:0] ckind,
    output logic       super_o,
    output logic       to_icache
);
    // Kind mapping; read-modify-write becomes atomic.
    always_comb begin
        case (kind)
            RQ_LOAD:   ckind = CQ_LD;
            RQ_IFETCH: ckind = CQ_IFETCH;
            RQ_STORE:  ckind = CQ_ST;
            default:   ckind = CQ_ATOMIC;
        endcase
    end

    assign super_o   = (mode == 2'd1);
    assign to_icache = (kind == RQ_IFETCH);
endmodule

// File: rtl/req_tracker.sv
// Outstanding memory request tracker. Admits or refuses requests, files
// them into a read or a write table by line address, forwards them on the
// instruction or data path, retires them on completion with a latency
// measure, and runs an age watchdog with a sticky deadlock flag.
// Assumes at most one request and one completion per cycle.
module req_tracker
    import req_tracker_pkg::*;
#(
    parameter int ENTRIES   = 8,
    parameter int MAX_OUT   = 12,
    parameter int DL_THRESH = 1024,
    parameter int DATA_W    = 64,
    parameter int OCC_W     = $clog2(ENTRIES + 1),
    parameter int CNT_W     = $clog2(2 * ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_accept,
    output logic              req_err,
    output logic [ID_W-1:0]   req_id,
    output logic              iss_i_valid,
    output logic              iss_d_valid,
    output logic [LINE_W-1:0] iss_line,
    output logic [OFF_W-1:0]  iss_off,
    output logic [LEN_W-1:0]  iss_len,
    output logic [1:0]        iss_kind,
    output logic              iss_super,
    input  logic              cpl_valid,
    input  logic              cpl_wr,
    input  logic [LINE_W-1:0] cpl_line,
    input  logic [DATA_W-1:0] cpl_data,
    output logic              done_valid,
    output logic              cpl_miss,
    output logic [ID_W-1:0]   done_id,
    output logic [1:0]        done_kind,
    output logic [OFF_W-1:0]  done_off,
    output logic [LEN_W-1:0]  done_len,
    output logic [DATA_W-1:0] done_data,
    output logic              lat_valid,
    output logic [TS_W-1:0]   latency,
    output logic [CNT_W-1:0]  outstanding,
    output logic              deadlock
);
    localparam int SUM_W = OFF_W + 2;

    logic [TS_W-1:0]  now;
    logic [ID_W-1:0]  id_ctr;
    logic [CNT_W-1:0] cnt_q, cnt_next;
    logic             is_wr, size_bad, dup, tbl_full, at_max, to_ic;
    logic             rd_probe, wr_probe, rd_full, wr_full, rd_hit, wr_hit;
    logic             rd_aged, wr_aged, wd_fire, dl_q;
    logic [OCC_W-1:0] rd_occ, wr_occ;
    slot_t            new_slot, rd_slot, wr_slot, hit_slot;

    assign iss_line = req_addr[ADDR_W-1:OFF_W];
    assign iss_off  = req_addr[OFF_W-1:0];
    assign iss_len  = req_len;
    assign is_wr    = req_kind[1];
    assign size_bad = ({2'b00, iss_off} + {1'b0, req_len}) > SUM_W'(LINE_BYTES);
    assign dup      = rd_probe || wr_probe;
    assign tbl_full = is_wr ? wr_full : rd_full;
    assign at_max   = cnt_q >= CNT_W'(MAX_OUT);

    assign req_err    = req_valid && size_bad;
    assign req_accept = req_valid && !size_bad && !dup && !tbl_full && !at_max;
    assign req_id     = req_accept ? id_ctr : '1;
    assign iss_i_valid = req_accept && to_ic;
    assign iss_d_valid = req_accept && !to_ic;

    assign new_slot = '{line: iss_line, id: id_ctr, kind: req_kind,
                        off: iss_off, len: req_len, ts: now};

    rt_xlate u_xlate (
        .kind(req_kind), .mode(req_mode), .ckind(iss_kind),
        .super_o(iss_super), .to_icache(to_ic)
    );

    rt_table #(.ENTRIES(ENTRIES), .THRESH(DL_THRESH)) u_rd_tbl (
        .clk(clk), .rst_n(rst_n), .probe_line(iss_line), .probe_hit(rd_probe),
        .ins_en(req_accept && !is_wr), .ins_slot(new_slot),
        .cpl_en(cpl_valid && !cpl_wr), .cpl_line(cpl_line), .cpl_hit(rd_hit),
        .cpl_slot(rd_slot), .now(now), .aged(rd_aged), .full(rd_full), .occ(rd_occ)
    );

    rt_table #(.ENTRIES(ENTRIES), .THRESH(DL_THRESH)) u_wr_tbl (
        .clk(clk), .rst_n(rst_n), .probe_line(iss_line), .probe_hit(wr_probe),
        .ins_en(req_accept && is_wr), .ins_slot(new_slot),
        .cpl_en(cpl_valid && cpl_wr), .cpl_line(cpl_line), .cpl_hit(wr_hit),
        .cpl_slot(wr_slot), .now(now), .aged(wr_aged), .full(wr_full), .occ(wr_occ)
    );

    assign done_valid = cpl_valid && (cpl_wr ? wr_hit : rd_hit);
    assign cpl_miss   = cpl_valid && !(cpl_wr ? wr_hit : rd_hit);
    assign hit_slot   = cpl_wr ? wr_slot : rd_slot;
    assign done_id    = hit_slot.id;
    assign done_kind  = hit_slot.kind;
    assign done_off   = hit_slot.off;
    assign done_len   = hit_slot.len;
    assign done_data  = cpl_data;
    assign latency    = now - hit_slot.ts;
    assign lat_valid  = done_valid && (latency != '0);

    assign cnt_next    = cnt_q + CNT_W'(req_accept) - CNT_W'(done_valid);
    assign outstanding = cnt_q;
    assign deadlock    = dl_q;

    rt_watchdog #(.THRESH(DL_THRESH)) u_wdog (
        .clk(clk), .rst_n(rst_n), .arm_req(req_accept),
        .any_left(cnt_next != '0), .fire(wd_fire)
    );

    // Free-running timestamp source.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end

    // Identifier allocation, never producing the all-ones refusal code.
    always_ff @(posedge clk) begin
        if (!rst_n)          id_ctr <= '0;
        else if (req_accept) id_ctr <= (id_ctr == {{(ID_W-1){1'b1}}, 1'b0}) ? '0 : id_ctr + 1'b1;
    end

    // Net outstanding count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next;
    end

    // Sticky deadlock flag set by an aged entry when the watchdog fires.
    always_ff @(posedge clk) begin
        if (!rst_n)                             dl_q <= 1'b0;
        else if (wd_fire && (rd_aged || wr_aged)) dl_q <= 1'b1;
    end
endmodule

// File: rtl/req_tracker_chk.sv
// Property checker for the request tracker, bound into every instance.
// Observes ports and the two table occupancies.
module req_tracker_chk
    import req_tracker_pkg::*;
#(
    parameter int MAX_OUT = 12,
    parameter int OCC_W   = 4,
    parameter int CNT_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_accept,
    input logic             req_err,
    input logic [ID_W-1:0]  req_id,
    input logic             iss_i_valid,
    input logic             iss_d_valid,
    input logic [1:0]       iss_kind,
    input logic             cpl_valid,
    input logic             done_valid,
    input logic [CNT_W-1:0] outstanding,
    input logic [OCC_W-1:0] rd_occ,
    input logic [OCC_W-1:0] wr_occ,
    input logic             deadlock
);
    p_cnt_tracks_tables_r12: assert property (@(posedge clk) disable iff (!rst_n)
        32'(outstanding) == 32'(rd_occ) + 32'(wr_occ));

    p_refuse_at_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(outstanding) >= MAX_OUT) |-> !req_accept);

    p_refused_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_accept) |-> (req_id == '1));

    p_size_err_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !req_accept);

    p_one_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({iss_i_valid, iss_d_valid}));

    p_accept_forwards_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |-> (iss_i_valid || iss_d_valid));

    p_ipath_is_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        iss_i_valid |-> (iss_kind == CQ_IFETCH));

    p_done_needs_cpl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> cpl_valid);

    p_deadlock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock |=> deadlock);
endmodule

bind req_tracker req_tracker_chk #(
    .MAX_OUT(MAX_OUT), .OCC_W(OCC_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_accept(req_accept),
    .req_err(req_err), .req_id(req_id), .iss_i_valid(iss_i_valid),
    .iss_d_valid(iss_d_valid), .iss_kind(iss_kind), .cpl_valid(cpl_valid),
    .done_valid(done_valid), .outstanding(outstanding), .rd_occ(rd_occ),
    .wr_occ(wr_occ), .deadlock(deadlock)
);

// File: tb/req_tracker_tb.sv
`timescale 1ns/1ps
module req_tracker_tb;
    localparam int ENTRIES = 8;
    localparam int MAXO    = 12;
    localparam int THR     = 100;
    localparam int CW      = $clog2(2 * ENTRIES + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0, req_mode = '0;
    logic [31:0] req_addr = '0;
    logic [6:0]  req_len = '0;
    logic        cpl_valid = 1'b0, cpl_wr = 1'b0;
    logic [25:0] cpl_line = '0;
    logic [63:0] cpl_data = '0;
    logic        req_accept, req_err, iss_i_valid, iss_d_valid, iss_super;
    logic [15:0] req_id, done_id;
    logic [25:0] iss_line;
    logic [5:0]  iss_off, done_off;
    logic [6:0]  iss_len, done_len;
    logic [1:0]  iss_kind, done_kind;
    logic        done_valid, cpl_miss, lat_valid, deadlock;
    logic [63:0] done_data;
    logic [31:0] latency;
    logic [CW-1:0] outstanding;

    int n_chk = 0, n_err = 0, nid = 0;
    bit finished = 0;

    // Snapshots taken mid-cycle
    logic s_acc, s_err, s_iv, s_dv, s_sup, s_done, s_miss, s_latv;
    logic [15:0] s_id, s_did;
    logic [25:0] s_line;
    logic [1:0]  s_kind, s_dkind;
    logic [5:0]  s_doff;
    logic [6:0]  s_dlen;
    logic [63:0] s_ddata;
    logic [31:0] s_lat;

    always #2.5 clk = ~clk;

    req_tracker #(.ENTRIES(ENTRIES), .MAX_OUT(MAXO), .DL_THRESH(THR)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_mode(req_mode), .req_addr(req_addr), .req_len(req_len),
        .req_accept(req_accept), .req_err(req_err), .req_id(req_id),
        .iss_i_valid(iss_i_valid), .iss_d_valid(iss_d_valid), .iss_line(iss_line),
        .iss_off(iss_off), .iss_len(iss_len), .iss_kind(iss_kind), .iss_super(iss_super),
        .cpl_valid(cpl_valid), .cpl_wr(cpl_wr), .cpl_line(cpl_line), .cpl_data(cpl_data),
        .done_valid(done_valid), .cpl_miss(cpl_miss), .done_id(done_id),
        .done_kind(done_kind), .done_off(done_off), .done_len(done_len),
        .done_data(done_data), .lat_valid(lat_valid), .latency(latency),
        .outstanding(outstanding), .deadlock(deadlock)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  mode;
        logic [31:0] addr;
        logic [6:0]  len;
        logic        acc;
        logic        err;
        logic [1:0]  ckind;
        logic        icache;
        logic        sup;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'd0, 2'd0, 32'h0000_1000, 7'd4,  1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        '{2'd1, 2'd1, 32'h0000_2040, 7'd8,  1'b1, 1'b0, 2'd3, 1'b1, 1'b1},
        '{2'd2, 2'd2, 32'h0000_3004, 7'd4,  1'b1, 1'b0, 2'd1, 1'b0, 1'b0},
        '{2'd3, 2'd1, 32'h0000_4010, 7'd8,  1'b1, 1'b0, 2'd2, 1'b0, 1'b1},
        '{2'd0, 2'd0, 32'h0000_1020, 7'd4,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
        '{2'd2, 2'd0, 32'h0000_2044, 7'd4,  1'b0, 1'b0, 2'd1, 1'b0, 1'b0},
        '{2'd0, 2'd0, 32'h0000_5030, 7'd17, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
        '{2'd0, 2'd0, 32'h0000_5030, 7'd16, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic rv, input logic [1:0] k, input logic [1:0] m,
                        input logic [31:0] a, input logic [6:0] l,
                        input logic cv, input logic cw, input logic [25:0] cl,
                        input logic [63:0] cd);
        @(negedge clk);
        req_valid = rv; req_kind = k; req_mode = m; req_addr = a; req_len = l;
        cpl_valid = cv; cpl_wr = cw; cpl_line = cl; cpl_data = cd;
        #1;
        s_acc = req_accept; s_err = req_err; s_id = req_id; s_iv = iss_i_valid;
        s_dv = iss_d_valid; s_sup = iss_super; s_kind = iss_kind; s_line = iss_line;
        s_done = done_valid; s_miss = cpl_miss; s_did = done_id; s_dkind = done_kind;
        s_doff = done_off; s_dlen = done_len; s_ddata = done_data;
        s_latv = lat_valid; s_lat = latency;
        @(posedge clk);
        #1;
        req_valid = 1'b0; cpl_valid = 1'b0;
    endtask

    task automatic req(input logic [1:0] k, input logic [1:0] m, input logic [31:0] a,
                       input logic [6:0] l);
        step(1'b1, k, m, a, l, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic cpl(input logic w, input logic [25:0] ln, input logic [63:0] d);
        step(1'b0, 2'd0, 2'd0, '0, '0, 1'b1, w, ln, d);
    endtask

    task automatic idle();
        step(1'b0, 2'd0, 2'd0, '0, '0, 1'b0, 1'b0, '0, '0);
    endtask

    // Hang guard
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // Reset state
        chk("R12 reset outstanding", 64'(outstanding), 0);
        chk("R11 reset deadlock", 64'(deadlock), 0);
        chk("R9 reset done_valid", 64'(done_valid), 0);

        // Vector walk: R1 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 8; i++) begin
            req(VEC[i].kind, VEC[i].mode, VEC[i].addr, VEC[i].len);
            chk("R3/R5 accept", 64'(s_acc), 64'(VEC[i].acc));
            chk("R5 req_err", 64'(s_err), 64'(VEC[i].err));
            chk("R4 id", 64'(s_id), VEC[i].acc ? 64'(nid) : 64'hFFFF);
            if (VEC[i].acc) begin
                chk("R8 ipath", 64'(s_iv), 64'(VEC[i].icache));
                chk("R8 dpath", 64'(s_dv), 64'(!VEC[i].icache));
                chk("R6 kind", 64'(s_kind), 64'(VEC[i].ckind));
                chk("R7 super", 64'(s_sup), 64'(VEC[i].sup));
                chk("R3 line", 64'(s_line), 64'(VEC[i].addr >> 6));
                nid++;
            end else begin
                chk("R8 no forward", 64'({s_iv, s_dv}), 0);
            end
        end
        chk("R12 count after vectors", 64'(outstanding), 5);

        // R1: completion against wrong table for the store line
        cpl(1'b0, 26'h0C0, 64'h1);
        chk("R1 wrong table no done", 64'(s_done), 0);
        chk("R9 miss flagged", 64'(s_miss), 1);
        chk("R1 count unchanged", 64'(outstanding), 5);
        cpl(1'b1, 26'h0C0, 64'hDEAD_BEEF_0123_4567);
        chk("R1 write done", 64'(s_done), 1);
        chk("R9 done id", 64'(s_did), 2);
        chk("R9 done off", 64'(s_doff), 4);
        chk("R9 done len", 64'(s_dlen), 4);
        chk("R9 done kind", 64'(s_dkind), 2);
        chk("R9 data pass", s_ddata, 64'hDEAD_BEEF_0123_4567);
        chk("R9 count drop", 64'(outstanding), 4);

        // R10 latency
        req(2'd0, 2'd0, 32'h6000, 7'd4);
        chk("R4 id5", 64'(s_id), 5);
        idle(); idle();
        cpl(1'b0, 26'h180, 64'h0);
        chk("R10 lat_valid", 64'(s_latv), 1);
        chk("R10 latency", 64'(s_lat), 3);
        chk("R10 count", 64'(outstanding), 4);

        // R12: insert and retire together
        step(1'b1, 2'd0, 2'd0, 32'h7000, 7'd4, 1'b1, 1'b1, 26'h100, 64'h5);
        chk("R12 accept", 64'(s_acc), 1);
        chk("R12 id6", 64'(s_id), 6);
        chk("R12 done", 64'(s_done), 1);
        chk("R12 done id3", 64'(s_did), 3);
        chk("R12 net count", 64'(outstanding), 4);

        // R13: fill the read table
        for (int i = 0; i < 4; i++) begin
            req(2'd0, 2'd0, 32'h8000 + 32'(64 * i), 7'd4);
            chk("R13 fill accept", 64'(s_acc), 1);
        end
        chk("R13 count 8", 64'(outstanding), 8);
        req(2'd0, 2'd0, 32'h9000, 7'd4);
        chk("R13 read full refused", 64'(s_acc), 0);
        chk("R4 refused id", 64'(s_id), 64'hFFFF);
        req(2'd2, 2'd0, 32'h9000, 7'd4);
        chk("R13 write still accepted", 64'(s_acc), 1);
        chk("R4 id11", 64'(s_id), 11);

        // R2: reach the cap
        for (int i = 0; i < 3; i++) req(2'd2, 2'd0, 32'hA000 + 32'(64 * i), 7'd4);
        chk("R2 count at cap", 64'(outstanding), 12);
        req(2'd2, 2'd0, 32'hB000, 7'd4);
        chk("R2 refused at cap", 64'(s_acc), 0);

        // Drain everything
        cpl(1'b0, 26'h081, 64'h0);
        chk("R9 fetch id", 64'(s_did), 1);
        chk("R9 fetch kind", 64'(s_dkind), 1);
        cpl(1'b0, 26'h040, 64'h0);
        cpl(1'b0, 26'h140, 64'h0);
        cpl(1'b0, 26'h1C0, 64'h0);
        for (int i = 0; i < 4; i++) cpl(1'b0, 26'h200 + 26'(i), 64'h0);
        cpl(1'b1, 26'h240, 64'h0);
        for (int i = 0; i < 3; i++) cpl(1'b1, 26'h280 + 26'(i), 64'h0);
        chk("R9 drained", 64'(outstanding), 0);

        // R11: quiet period then a held request
        repeat (120) @(posedge clk);
        #1 chk("R11 no false deadlock", 64'(deadlock), 0);
        req(2'd0, 2'd0, 32'hC000, 7'd4);
        chk("R11 held accepted", 64'(s_acc), 1);
        repeat (90) @(posedge clk);
        #1 chk("R11 not yet", 64'(deadlock), 0);
        repeat (15) @(posedge clk);
        #1 chk("R11 deadlock raised", 64'(deadlock), 1);
        cpl(1'b0, 26'h300, 64'h0);
        repeat (5) @(posedge clk);
        #1 chk("R11 sticky", 64'(deadlock), 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule